// File: doc/BRIEF.md
# APB Inter-Core Interrupt Mailbox

This block lets processor cores raise interrupts on each other through a small APB3 register set. A source core writes a bit mask to the set register, which marks the matching interrupt lines as pending. The target core reads a status register to see which lines are pending. It acknowledges them by writing a mask to the clear register. A per-line enable mask selects which pending lines drive the level-sensitive interrupt outputs. This lets a core silence a line without losing the pending state behind it.

The completer inserts a fixed number of wait states, set by a parameter from 0 to 3, into every access phase. It answers an access to an unmapped location, or a write to the read-only status register, with an error response and leaves all state untouched. Only the interrupt lines leave the block. Routing them to cores happens elsewhere.

Register offsets (byte addresses, word aligned): 0x0 set, 0x4 clear, 0x8 pending status, 0xC enable mask. Interrupt line i corresponds to data bit i.

Top module: `irq_mailbox_apb`

## Requirements
- R1: After a synchronous active-low reset, all pending bits, all enable bits and all interrupt outputs are 0.
- R2: A completed write to offset 0x0 makes pending bit i 1 for each data bit i (i < NUM_IRQ) that is 1. Other pending bits keep their values, and data bits at or above NUM_IRQ are ignored.
- R3: A completed write to offset 0x4 makes pending bit i 0 for each data bit i that is 1. Pending bits whose data bit is 0 keep their values.
- R4: A read of offset 0x8 returns the pending bits in data bits NUM_IRQ-1..0 with the upper bits 0. A read of offset 0xC returns the enable mask the same way, and a write to 0xC replaces the mask.
- R5: Interrupt output i is high exactly when pending bit i and enable bit i are both 1. It updates in the cycle after the write that changes either bit.
- R6: In every access phase, PREADY stays low for WAIT_CYCLES cycles and rises in the following cycle, for reads and writes alike.
- R7: An access to any address other than 0x0, 0x4, 0x8 or 0xC ends with PSLVERR high in its final cycle. This covers nonzero upper bits and unaligned addresses. Such an access returns read data 0 and changes no pending or enable bit.
- R8: A write to offset 0x8 ends with PSLVERR high and changes no state.
- R9: PREADY, PSLVERR and PRDATA are 0 whenever PSEL is low, and also during the setup phase, when PENABLE is low.
- R10: Reads of offsets 0x0 and 0x4 return 0 with PSLVERR low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Synchronous reset, active low |
| psel | input | 1 | Completer select |
| penable | input | 1 | Access phase marker |
| paddr | input | ADDR_W | Byte address |
| pwrite | input | 1 | 1 = write, 0 = read |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, valid in the final access cycle |
| pready | output | 1 | Transfer completes in this cycle |
| pslverr | output | 1 | Error response, valid with pready |
| irq | output | NUM_IRQ | Level interrupt lines, pending AND enable |

## Verification
A corrupted pending or enable bit appears on the irq lines in the very next cycle. It also appears in the next status or mask read, so the bench reads both registers back after every change and compares each with a model kept from the requirements. A wrong wait counter changes how many low-PREADY cycles the bench counts inside the access phase, which is checked on every transfer. A decode fault shows up as a missing or spurious PSLVERR, or as a register that changes after an erroring access. The read-back that follows that access exposes it at once.

// File: rtl/mbx_pkg.sv
// Package: shared register selector type and offsets for the interrupt mailbox.
// Assumes word-aligned 32-bit-style register spacing (byte offsets 0,4,8,C).
package mbx_pkg;

    // Register selected by address bits [3:2]
    typedef enum logic [1:0] {
        RS_SET  = 2'd0,
        RS_CLR  = 2'd1,
        RS_STAT = 2'd2,
        RS_MASK = 2'd3
    } reg_sel_e;

    localparam int unsigned SEL_LSB = 2;
    localparam int unsigned MAP_W   = 4;   // byte-address bits covered by the map

endpackage

// File: rtl/mbx_addr_dec.sv
// Module: address decoder for the mailbox register window.
// Maps a byte address to one of four registers and flags addresses that
// fall outside the window or are unaligned, plus writes to the read-only
// status register. Purely combinational; assumes ADDR_W > MAP_W.
module mbx_addr_dec
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_write,
    output reg_sel_e          sel,
    output logic              bad
);

    logic in_window;
    logic aligned;

    // Classify the address and pick the register
    always_comb begin
        in_window = (addr[ADDR_W-1:MAP_W] == '0);
        aligned   = (addr[SEL_LSB-1:0] == '0);
        sel       = reg_sel_e'(addr[MAP_W-1:SEL_LSB]);
        bad       = !in_window || !aligned || (is_write && sel == RS_STAT);
    end

endmodule

// File: rtl/mbx_wait_gen.sv
// Module: wait-state generator for the APB access phase.
// Counts access-phase cycles and raises ready after WAIT_CYCLES stalled
// cycles. Assumes 0 <= WAIT_CYCLES <= 3 and that the requester holds the
// access until ready is seen. Synchronous active-low reset.
module mbx_wait_gen #(
    parameter int unsigned WAIT_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic access,
    output logic ready
);

    localparam int unsigned CNT_W  = 2;
    localparam logic [CNT_W-1:0] WAIT_V = CNT_W'(WAIT_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    // Ready once the stall count reaches the configured number of waits
    always_comb ready = (cnt_q == WAIT_V);

    // Advance the stall count during a stalled access, restart otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (access && !ready) cnt_q <= cnt_q + 1'b1;
        else                       cnt_q <= '0;
    end

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= WAIT_V);

    // R6
    stall_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !ready) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R6
    idle_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !access |=> (cnt_q == '0));

endmodule

// File: rtl/mbx_irq_regs.sv
// Module: pending and enable storage for the interrupt lines.
// Pending bits are set and cleared by per-bit strobes, with set taking
// priority when both hit the same bit. The enable mask is loaded whole.
// Synchronous active-low reset clears everything.
module mbx_irq_regs #(
    parameter int unsigned NUM_IRQ = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] set_vec,
    input  logic [NUM_IRQ-1:0] clr_vec,
    input  logic               mask_we,
    input  logic [NUM_IRQ-1:0] mask_d,
    output logic [NUM_IRQ-1:0] pending,
    output logic [NUM_IRQ-1:0] enable
);

    // Per-bit pending flops, set has priority over clear
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_pend
        always_ff @(posedge clk) begin
            if (!rst_n)          pending[i] <= 1'b0;
            else if (set_vec[i]) pending[i] <= 1'b1;
            else if (clr_vec[i]) pending[i] <= 1'b0;
        end
    end

    // Enable mask register
    always_ff @(posedge clk) begin
        if (!rst_n)       enable <= '0;
        else if (mask_we) enable <= mask_d;
    end

    // R2
    set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((pending & $past(set_vec)) == $past(set_vec)));

    // R3
    clr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec != '0) |=> ((pending & $past(clr_vec & ~set_vec)) == '0));

    // R7
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec == '0 && clr_vec == '0) |=> (pending == $past(pending)));

    // R7
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> (enable == $past(enable)));

endmodule

// File: rtl/irq_mailbox_apb.sv
// Module: APB3 completer carrying an inter-core interrupt mailbox.
// Registers: 0x0 write-1-set, 0x4 write-1-clear, 0x8 pending (read-only),
// 0xC enable mask. irq = pending & enable. Inserts WAIT_CYCLES wait states
// per access and answers bad addresses or status writes with PSLVERR and no
// state change. Response outputs are zero outside the access phase.
// Assumes NUM_IRQ <= DATA_W, ADDR_W > 4, WAIT_CYCLES in 0..3.
module irq_mailbox_apb
    import mbx_pkg::*;
#(
    parameter int unsigned NUM_IRQ     = 8,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned WAIT_CYCLES = 2
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic [ADDR_W-1:0] paddr,
    input  logic              pwrite,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    output logic [NUM_IRQ-1:0] irq
);

    logic               access;
    logic               wait_done;
    logic               dec_bad;
    reg_sel_e           dec_sel;
    logic               commit;
    logic [NUM_IRQ-1:0] wr_bits;
    logic [NUM_IRQ-1:0] set_vec;
    logic [NUM_IRQ-1:0] clr_vec;
    logic               mask_we;
    logic [NUM_IRQ-1:0] pend_q;
    logic [NUM_IRQ-1:0] mask_q;
    logic [DATA_W-1:0]  rd_word;

    // Access phase of an addressed transfer
    always_comb access = psel && penable;

    mbx_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr     (paddr),
        .is_write (pwrite),
        .sel      (dec_sel),
        .bad      (dec_bad)
    );

    mbx_wait_gen #(.WAIT_CYCLES(WAIT_CYCLES)) u_wait (
        .clk    (pclk),
        .rst_n  (presetn),
        .access (access),
        .ready  (wait_done)
    );

    // Turn a completing good write into per-register strobes
    always_comb begin
        commit  = access && wait_done && pwrite && !dec_bad;
        wr_bits = pwdata[NUM_IRQ-1:0];
        set_vec = (commit && dec_sel == RS_SET) ? wr_bits : '0;
        clr_vec = (commit && dec_sel == RS_CLR) ? wr_bits : '0;
        mask_we = commit && dec_sel == RS_MASK;
    end

    mbx_irq_regs #(.NUM_IRQ(NUM_IRQ)) u_regs (
        .clk     (pclk),
        .rst_n   (presetn),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .mask_we (mask_we),
        .mask_d  (wr_bits),
        .pending (pend_q),
        .enable  (mask_q)
    );

    // Select the read word, zero-extended
    always_comb begin
        rd_word = '0;
        unique case (dec_sel)
            RS_STAT: rd_word[NUM_IRQ-1:0] = pend_q;
            RS_MASK: rd_word[NUM_IRQ-1:0] = mask_q;
            default: rd_word = '0;
        endcase
    end

    // Drive the response only in the final access cycle
    always_comb begin
        pready  = access && wait_done;
        pslverr = pready && dec_bad;
        prdata  = (pready && !pwrite && !dec_bad) ? rd_word : '0;
    end

    // Gate pending lines with their enables
    always_comb irq = pend_q & mask_q;

    // R9
    idle_quiet_chk: assert property (@(posedge pclk) disable iff (!presetn)
        !(psel && penable) |-> (!pready && !pslverr && prdata == '0));

    // R7
    err_no_effect_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (pready && pslverr) |=> (irq == $past(irq)));

    // R8
    stat_write_err_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (pready && pwrite && paddr == ADDR_W'(8)) |-> pslverr);

    // R5
    irq_gate_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (irq & ~mask_q) == '0);

endmodule

// File: tb/sim_irq_mailbox_apb.sv
// Directed bench for the interrupt mailbox: one task per scenario.
module sim_irq_mailbox_apb;

    localparam int unsigned NUM_IRQ = 8;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned ADDR_W  = 12;
    localparam int unsigned WAITS   = 2;
    localparam time         CLK_PERIOD = 10ns;

    logic              pclk = 1'b0;
    logic              presetn = 1'b0;
    logic              psel = 1'b0;
    logic              penable = 1'b0;
    logic [ADDR_W-1:0] paddr = '0;
    logic              pwrite = 1'b0;
    logic [DATA_W-1:0] pwdata = '0;
    logic [DATA_W-1:0] prdata;
    logic              pready;
    logic              pslverr;
    logic [NUM_IRQ-1:0] irq;

    int checks = 0;
    int errors = 0;
    logic [NUM_IRQ-1:0] exp_pend = '0;
    logic [NUM_IRQ-1:0] exp_mask = '0;

    irq_mailbox_apb #(
        .NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WAIT_CYCLES(WAITS)
    ) u0 (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .paddr(paddr), .pwrite(pwrite), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .irq(irq)
    );

    always #(CLK_PERIOD/2) pclk = ~pclk;

    task automatic check(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One APB transfer; checks wait count and setup-phase quiet outputs
    task automatic apb_xfer(input logic wr, input logic [ADDR_W-1:0] a,
                            input logic [DATA_W-1:0] d,
                            output logic [DATA_W-1:0] rd, output logic err);
        int waits = 0;
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
        #1;
        check("R9 setup quiet", {pready, pslverr, prdata != '0}, '0);
        @(negedge pclk);
        penable = 1'b1;
        #1;
        while (!pready && waits < 8) begin
            waits++;
            @(negedge pclk);
            #1;
        end
        check("R6 wait count", waits, WAITS);
        rd = prdata; err = pslverr;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0;
        #1;
        check("R9 idle quiet", {pready, pslverr, prdata != '0}, '0);
    endtask

    task automatic read_back(input string req);
        logic [DATA_W-1:0] rd; logic err;
        apb_xfer(1'b0, 12'h008, '0, rd, err);
        check({req, " status"}, rd, DATA_W'(exp_pend));
        apb_xfer(1'b0, 12'h00C, '0, rd, err);
        check({req, " mask"}, rd, DATA_W'(exp_mask));
        check({req, " irq"}, DATA_W'(irq), DATA_W'(exp_pend & exp_mask));
    endtask

    task automatic t_reset();
        check("R1 irq after reset", DATA_W'(irq), '0);
        read_back("R1");
    endtask

    task automatic t_set();
        logic [DATA_W-1:0] rd; logic err;
        apb_xfer(1'b1, 12'h00C, 32'h0000_00FF, rd, err);
        exp_mask = 8'hFF;
        check("R4 mask write err", err, 0);
        apb_xfer(1'b1, 12'h000, 32'hFFFF_0105, rd, err);
        exp_pend = 8'h05;
        check("R2 set err", err, 0);
        @(negedge pclk);
        check("R5 irq after set", DATA_W'(irq), 32'h05);
        read_back("R2");
        apb_xfer(1'b1, 12'h000, 32'h0000_00A0, rd, err);
        exp_pend = 8'hA5;
        read_back("R2 accumulate");
    endtask

    task automatic t_mask();
        logic [DATA_W-1:0] rd; logic err;
        apb_xfer(1'b1, 12'h00C, 32'h0000_0024, rd, err);
        exp_mask = 8'h24;
        read_back("R5 masked");
        check("R5 irq masked", DATA_W'(irq), 32'h24);
        apb_xfer(1'b1, 12'h00C, 32'h0000_00F0, rd, err);
        exp_mask = 8'hF0;
        read_back("R4 mask update");
    endtask

    task automatic t_clear();
        logic [DATA_W-1:0] rd; logic err;
        apb_xfer(1'b1, 12'h004, 32'h0000_0021, rd, err);
        exp_pend = 8'h84;
        check("R3 clear err", err, 0);
        read_back("R3");
        apb_xfer(1'b1, 12'h004, 32'h0000_0000, rd, err);
        read_back("R3 zero mask");
    endtask

    task automatic t_errors();
        logic [DATA_W-1:0] rd; logic err;
        apb_xfer(1'b1, 12'h010, 32'hFFFF_FFFF, rd, err);
        check("R7 out of window write", err, 1);
        apb_xfer(1'b1, 12'h101, 32'hFFFF_FFFF, rd, err);
        check("R7 high bits write", err, 1);
        apb_xfer(1'b1, 12'h002, 32'hFFFF_FFFF, rd, err);
        check("R7 unaligned set", err, 1);
        apb_xfer(1'b1, 12'h00E, 32'h0000_0000, rd, err);
        check("R7 unaligned mask", err, 1);
        apb_xfer(1'b0, 12'h108, '0, rd, err);
        check("R7 bad read err", err, 1);
        check("R7 bad read data", rd, '0);
        read_back("R7 no change");
        apb_xfer(1'b1, 12'h008, 32'h0000_00FF, rd, err);
        check("R8 status write err", err, 1);
        read_back("R8 no change");
    endtask

    task automatic t_write_only_reads();
        logic [DATA_W-1:0] rd; logic err;
        apb_xfer(1'b0, 12'h000, '0, rd, err);
        check("R10 set read data", rd, '0);
        check("R10 set read err", err, 0);
        apb_xfer(1'b0, 12'h004, '0, rd, err);
        check("R10 clear read data", rd, '0);
        check("R10 clear read err", err, 0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge pclk);
        presetn = 1'b1;
        @(negedge pclk);
        t_reset();
        t_set();
        t_mask();
        t_clear();
        t_errors();
        t_write_only_reads();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule